// File: doc/BRIEF.md
# Three-Wire Serial Shift Interface

This block is a byte-wide synchronous serial port with three signals: a serial clock, a data output and a data input. One 8-bit shift register does both jobs. On each transfer it sends its contents out and collects the incoming bits in the same places. Software writes a byte to start a transfer. When the eighth bit has been exchanged, the port stops by itself and raises an interrupt request flag. That flag stays set until software clears it.

The serial clock rests high. Output bits change on its falling edge, and input bits are sampled on its rising edge. In master mode, a programmable divider makes the serial clock from the system clock. In slave mode, an external clock is brought through a two-flop synchronizer, and its edges are detected in the system clock domain. A mode input picks whether the most significant or the least significant bit goes first. The order is set by mirroring the byte on the parallel write and read paths, so the register always shifts the same way.

Top module: `tw_serial_port`

## Requirements
- R1: After reset, sck_out and so_out are 1, busy and irq are 0, and rd_data is 0x00.
- R2: A wr_en pulse with cfg_enable=1 while busy=0 starts a transfer, and busy is 1 in the following cycle.
- R3: A write made while cfg_enable=0 starts nothing. Setting cfg_enable to 1 afterwards still starts nothing: busy stays 0 and the serial clock stays high.
- R4: With cfg_lsb_first=0 at the write, so_out carries wr_data bit 7 first and bit 0 last. Each bit appears on a falling edge of the serial clock.
- R5: With cfg_lsb_first=1 at the write, so_out carries wr_data bit 0 first and bit 7 last.
- R6: si_in is sampled on each rising serial clock edge. Afterwards, rd_data holds the received byte. With cfg_lsb_first=0 at the read, the first received bit is bit 7. With cfg_lsb_first=1 at the read, the first received bit is bit 0.
- R7: Changing cfg_lsb_first after the write does not change the bit sequence sent for that byte.
- R8: After the eighth rising serial clock edge, busy returns to 0, the serial clock stays high and irq is set, all on the same system clock edge.
- R9: irq stays 1 until a cycle in which irq_clr=1 and no transfer is ending. If completion and irq_clr occur in the same cycle, completion wins.
- R10: A wr_en pulse while busy=1 is ignored. The current byte goes out unchanged, and no second transfer follows.
- R11: In master mode (cfg_master=1), each serial clock half-period lasts cfg_div+1 system clock cycles.
- R12: In slave mode (cfg_master=0), the transfer is clocked by the edges of sck_in, and sck_out stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Port enable; gates the start of a transfer |
| cfg_master | input | 1 | 1: internal clock drives sck_out; 0: sck_in clocks the transfer |
| cfg_lsb_first | input | 1 | Bit order for the parallel write and read paths |
| cfg_div | input | DIV_W | Master half-period minus one, in system clocks |
| wr_en | input | 1 | Data write strobe |
| wr_data | input | 8 | Byte to transmit |
| rd_data | output | 8 | Shift register contents, in the selected order |
| irq_clr | input | 1 | Write-one-to-clear strobe for irq |
| irq | output | 1 | Transfer complete request flag |
| busy | output | 1 | A transfer is in progress |
| sck_out | output | 1 | Serial clock output (master) |
| sck_in | input | 1 | Serial clock input (slave) |
| so_out | output | 1 | Serial data output latch |
| si_in | input | 1 | Serial data input |

## Verification
A wrong bit counter shows up at the ports within one byte time, as a transfer that has too few or too many clock pulses, or an irq that arrives at the wrong moment. A bad mirror or shift path changes the bit sequence on so_out starting with its first bit, or makes rd_data differ at the moment irq rises. Faulty start gating is seen within a cycle or two: busy rises when it should not, or the serial clock moves when it should be at rest. A divider fault shows up on the second serial clock edge as a half-period of the wrong length.

// File: rtl/tw_serial_pkg.sv
package tw_serial_pkg;
  localparam int BYTE_W    = 8;
  localparam int BIT_CNT_W = $clog2(BYTE_W);

  typedef logic [BYTE_W-1:0] sio_byte_t;

  // Reverse bit positions of a byte (used on the parallel gates only).
  function automatic sio_byte_t mirror_byte(input sio_byte_t v);
    sio_byte_t r;
    for (int i = 0; i < BYTE_W; i++) r[i] = v[BYTE_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/tw_sck_gen.sv
module tw_sck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic             sck_in,
  output logic             sck_out,
  output logic             fall_ev,
  output logic             rise_ev
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sck_q, sck_d;
  logic             sync1_q, sync2_q, sync3_q;
  logic             tick;

  // Master divider: next state
  always_comb begin
    tick  = run && master && (cnt_q == div);
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (!run || !master) begin
      cnt_d = '0;
      sck_d = 1'b1;
    end else if (tick) begin
      cnt_d = '0;
      sck_d = ~sck_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  // Slave clock synchronizer plus one stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      sync3_q <= 1'b1;
    end else begin
      sync1_q <= sck_in;
      sync2_q <= sync1_q;
      sync3_q <= sync2_q;
    end
  end

  always_comb begin
    if (master) begin
      fall_ev = tick && sck_q;
      rise_ev = tick && !sck_q;
    end else begin
      fall_ev = run && !sync2_q && sync3_q;
      rise_ev = run && sync2_q && !sync3_q;
    end
  end

  assign sck_out = sck_q;
endmodule

// File: rtl/tw_shift_core.sv
module tw_shift_core
  import tw_serial_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  sio_byte_t load_val,
  input  logic      fall_ev,
  input  logic      rise_ev,
  input  logic      si,
  output sio_byte_t shreg,
  output logic      so,
  output logic      busy,
  output logic      done
);
  sio_byte_t            sh_q, sh_d;
  logic                 so_q, so_d;
  logic                 busy_q, busy_d;
  logic [BIT_CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    sh_d   = sh_q;
    so_d   = so_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done   = rise_ev && busy_q && (cnt_q == BIT_CNT_W'(BYTE_W-1));
    if (load) begin
      sh_d   = load_val;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else begin
      // output latch follows the end bit on the falling edge
      if (fall_ev && busy_q) so_d = sh_q[BYTE_W-1];
      // input enters the opposite end on the rising edge
      if (rise_ev && busy_q) begin
        sh_d  = {sh_q[BYTE_W-2:0], si};
        cnt_d = cnt_q + 1'b1;
      end
      if (done) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      so_q   <= 1'b1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      so_q   <= so_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign shreg = sh_q;
  assign so    = so_q;
  assign busy  = busy_q;
endmodule

// File: rtl/tw_serial_port.sv
module tw_serial_port
  import tw_serial_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_master,
  input  logic             cfg_lsb_first,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  input  logic             irq_clr,
  output logic             irq,
  output logic             busy,
  output logic             sck_out,
  input  logic             sck_in,
  output logic             so_out,
  input  logic             si_in
);
  logic      start;
  sio_byte_t load_val, shreg;
  logic      fall_ev, rise_ev, done, busy_w;
  logic      irq_q, irq_d;

  // start gate: enabled and idle at the moment of the write
  assign start    = wr_en && cfg_enable && !busy_w;
  assign load_val = cfg_lsb_first ? mirror_byte(wr_data) : wr_data;

  tw_sck_gen #(.DIV_W(DIV_W)) u_sck (
    .clk     (clk),
    .rst_n   (rst_n),
    .master  (cfg_master),
    .run     (busy_w),
    .div     (cfg_div),
    .sck_in  (sck_in),
    .sck_out (sck_out),
    .fall_ev (fall_ev),
    .rise_ev (rise_ev)
  );

  tw_shift_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_val (load_val),
    .fall_ev  (fall_ev),
    .rise_ev  (rise_ev),
    .si       (si_in),
    .shreg    (shreg),
    .so       (so_out),
    .busy     (busy_w),
    .done     (done)
  );

  // request flag: completion has priority over the clear strobe
  always_comb begin
    irq_d = irq_q;
    if (done)         irq_d = 1'b1;
    else if (irq_clr) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq     = irq_q;
  assign busy    = busy_w;
  assign rd_data = cfg_lsb_first ? mirror_byte(shreg) : shreg;
endmodule

// File: rtl/tw_serial_port_chk.sv
module tw_serial_port_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_enable,
  input logic cfg_master,
  input logic wr_en,
  input logic irq_clr,
  input logic busy,
  input logic irq,
  input logic sck_out,
  input logic so_out
);
  // R2
  start_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && wr_en && cfg_enable |=> busy);
  // R3
  no_spurious_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !(wr_en && cfg_enable) |=> !busy);
  // R8
  sck_rest_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck_out);
  // R8
  irq_at_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $fell(busy));
  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);
  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr && !busy |=> !irq);
  // R4
  so_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master && $stable(cfg_master) && !$fell(sck_out) |-> $stable(so_out));
  // R12
  slave_sck_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master && !$past(cfg_master) |-> sck_out);
endmodule

bind tw_serial_port tw_serial_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_enable (cfg_enable),
  .cfg_master (cfg_master),
  .wr_en      (wr_en),
  .irq_clr    (irq_clr),
  .busy       (busy),
  .irq        (irq),
  .sck_out    (sck_out),
  .so_out     (so_out)
);

// File: tb/tb_tw_serial_port.sv
`timescale 1ns/1ps
module tb_tw_serial_port;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_enable = 1'b0, cfg_master = 1'b1, cfg_lsb_first = 1'b0;
  logic [DIV_W-1:0] cfg_div = '0;
  logic             wr_en = 1'b0;
  logic [7:0]       wr_data = '0;
  logic [7:0]       rd_data;
  logic             irq_clr = 1'b0;
  logic             irq, busy, sck_out, so_out;
  logic             sck_in = 1'b1, si_in = 1'b0;

  tw_serial_port #(.DIV_W(DIV_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_master(cfg_master),
    .cfg_lsb_first(cfg_lsb_first), .cfg_div(cfg_div), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq_clr(irq_clr), .irq(irq),
    .busy(busy), .sck_out(sck_out), .sck_in(sck_in), .so_out(so_out), .si_in(si_in)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [7:0] tx_wire;
    logic [7:0] si_wire;
    logic [7:0] rx_exp;
    int         half;
    string      req;
  } item_t;

  item_t sb_q[$];
  int n_tests = 0, n_fail = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  // driver: push expectation, then write the byte
  task automatic send(input logic [7:0] d, input logic [7:0] si_w, input bit load_lsb,
                      input bit read_lsb, input int half, input string req);
    item_t it;
    it.tx_wire = load_lsb ? rev8(d) : d;
    it.si_wire = si_w;
    it.rx_exp  = read_lsb ? rev8(si_w) : si_w;
    it.half    = half;
    it.req     = req;
    sb_q.push_back(it);
    do_write(d);
  endtask

  task automatic do_write(input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 4000) begin @(negedge clk); n++; end
    chk(irq === 1'b1, req, irq, 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_irq();
    @(posedge clk); #1; irq_clr = 1'b1;
    @(posedge clk); #1; irq_clr = 1'b0;
  endtask

  // monitor: acts as the far end of the link and scores finished transfers
  initial begin : monitor
    logic prev_line = 1'b1, prev_irq = 1'b0, line;
    logic [7:0] wire_b = '0;
    int idx = 0, tcount = 0, last_cyc = 0;
    bit period_bad = 0, slave_bad = 0;
    item_t it;
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      line = cfg_master ? sck_out : sck_in;
      if (!cfg_master && sck_out !== 1'b1) slave_bad = 1;
      if (line !== prev_line) begin
        if (sb_q.size() == 0) begin
          chk(0, "R3 R10 unexpected serial clock", line, prev_line);
        end else begin
          if (tcount > 0 && sb_q[0].half != 0 && (cyc - last_cyc) != sb_q[0].half)
            period_bad = 1;
          last_cyc = cyc;
          tcount++;
          if (!line) si_in = sb_q[0].si_wire[7-idx];
          else if (idx < 8) begin wire_b[7-idx] = so_out; idx++; end
        end
      end
      prev_line = line;
      if (irq && !prev_irq) begin
        if (sb_q.size() == 0) chk(0, "R8 unexpected irq", irq, 0);
        else begin
          it = sb_q.pop_front();
          chk(idx == 8, "R8 bit count", idx, 8);
          chk(wire_b == it.tx_wire, it.req, wire_b, it.tx_wire);
          chk(rd_data == it.rx_exp, "R6 received byte", rd_data, it.rx_exp);
          chk(busy == 1'b0 && line == 1'b1, "R8 stopped and high", {busy, line}, 1);
          chk(!period_bad, "R11 half-period", period_bad, 0);
          chk(!slave_bad, "R12 sck_out held high", slave_bad, 0);
        end
        idx = 0; tcount = 0; period_bad = 0; slave_bad = 0;
      end
      prev_irq = irq;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sck_out == 1'b1 && so_out == 1'b1, "R1 lines", {sck_out, so_out}, 3);
    chk(busy == 1'b0 && irq == 1'b0, "R1 flags", {busy, irq}, 0);
    chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);

    // R2 / R4 / R11: MSB-first master, half-period 2
    cfg_enable = 1'b1; cfg_div = 8'd1;
    send(8'hA5, 8'h3C, 1'b0, 1'b0, 2, "R4 msb-first wire");
    @(negedge clk);
    chk(busy == 1'b1, "R2 busy after write", busy, 1);
    wait_irq("R8 irq");
    // R9 hold then clear
    repeat (10) @(negedge clk);
    chk(irq == 1'b1, "R9 irq held", irq, 1);
    clear_irq();
    @(negedge clk);
    chk(irq == 1'b0, "R9 irq cleared", irq, 0);

    // R5 / R11: LSB-first, half-period 4, clear held high across completion
    cfg_lsb_first = 1'b1; cfg_div = 8'd3;
    send(8'hC6, 8'h9E, 1'b1, 1'b1, 4, "R5 lsb-first wire");
    @(posedge clk); #1; irq_clr = 1'b1;
    wait_irq("R9 set wins over clear");
    irq_clr = 1'b0;
    clear_irq();

    // R7: order switched after the write
    cfg_lsb_first = 1'b0; cfg_div = 8'd2;
    send(8'h17, 8'h4D, 1'b0, 1'b1, 3, "R7 order change ignored");
    @(posedge clk); #1; cfg_lsb_first = 1'b1;
    wait_irq("R7 irq");
    cfg_lsb_first = 1'b0;
    clear_irq();

    // R10: write while busy
    cfg_div = 8'd1;
    send(8'h5A, 8'hC3, 1'b0, 1'b0, 2, "R10 first byte intact");
    repeat (6) @(posedge clk);
    do_write(8'hFF);
    wait_irq("R10 irq");
    repeat (30) @(negedge clk);
    chk(busy == 1'b0, "R10 no second transfer", busy, 0);
    clear_irq();

    // R3: write while disabled, then enable
    cfg_enable = 1'b0;
    do_write(8'h99);
    @(negedge clk);
    chk(busy == 1'b0, "R3 disabled write", busy, 0);
    cfg_enable = 1'b1;
    repeat (20) @(negedge clk);
    chk(busy == 1'b0 && irq == 1'b0 && sck_out == 1'b1, "R3 late enable", {busy, irq, sck_out}, 1);

    // R12: slave mode, LSB-first, external clock
    cfg_master = 1'b0; cfg_lsb_first = 1'b1;
    send(8'h3B, 8'h72, 1'b1, 1'b1, 0, "R12 slave wire");
    for (int b = 0; b < 8; b++) begin
      repeat (6) @(posedge clk); #1; sck_in = 1'b0;
      repeat (6) @(posedge clk); #1; sck_in = 1'b1;
    end
    wait_irq("R12 irq");
    clear_irq();
    chk(sb_q.size() == 0, "R8 all transfers scored", sb_q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule